// File: doc/BRIEF.md
# T1 Per-Channel Gating Signal Generator

This block drives two channel-gating outputs, one for the receive path and one for the transmit path of a T1 line. Each output follows the 193-bit T1 frame, which is one framing bit followed by 24 timeslots of 8 bits each. Over every timeslot the output is held high or low for the whole slot, as a 24-bit mask selects. Over the framing bit the output is always low. A downstream HDLC or fractional-T1 serial controller can AND its bit clock with the output, so that it only sees the timeslots it owns.

Each path takes its own bit-clock enable strobe and its own frame-sync pulse. Each path also has its own bank of three byte-wide mask registers on a shared write-only host bus. A mask write is staged and only reaches the output at the next framing bit, so no frame is ever produced from a half-updated mask.

Top module: `t1_chan_gate`

## Requirements
- R1: During the framing-bit position the gate output is low, whatever the mask holds.
- R2: When a channel's mask bit is 1, the gate output is high for all 8 bit times of that channel's timeslot.
- R3: When a channel's mask bit is 0, the gate output is low for all 8 bit times of that channel's timeslot.
- R4: Channel n (1..24) maps to bit (n-1)%8 of the mask byte at address BASE+(n-1)/8. Channel 1 is bit 0 at BASE and channel 24 is bit 7 at BASE+2. The receive BASE is 0x6C and the transmit BASE is 0x32.
- R5: A mask write takes effect at the next framing bit. The rest of the current frame keeps using the previous mask.
- R6: A bit strobe with frame sync high starts the framing bit, at any point in the frame. Without frame sync, the position advances by one per strobe and wraps to the framing bit after 193 bits.
- R7: The gate output changes only on a clock edge where that path's bit strobe is high. It is updated on the edge that starts each bit, and it holds at all other times.
- R8: The receive and transmit paths are independent. A write to one bank, or a strobe on one path, leaves the other output unchanged.
- R9: Writes to addresses outside 0x6C..0x6E and 0x32..0x34 change neither mask.
- R10: While reset is asserted both outputs are low. After reset both masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| rx_bit_en | input | 1 | Receive bit-time strobe, one cycle per line bit |
| rx_fsync | input | 1 | Receive frame sync, qualified by rx_bit_en |
| rx_gate | output | 1 | Receive channel gating output |
| tx_bit_en | input | 1 | Transmit bit-time strobe |
| tx_fsync | input | 1 | Transmit frame sync, qualified by tx_bit_en |
| tx_gate | output | 1 | Transmit channel gating output |

## Verification
The bench builds the block with its default parameters: 24 channels of 8 bits, an 8-bit address, and bank bases 0x6C and 0x32. These values put the full 193-bit frame within reach, including the wrap without frame sync. They also reach the lowest and highest mask bits (channel 1 and channel 24), and the decode edges just outside each bank (0x6B, 0x6F, 0x31, 0x35). A reference position counter and staged/active mask copies in the bench predict every bit of both outputs. This also covers a mid-frame mask write and a mid-frame frame-sync realignment.

// File: rtl/t1cg_pkg.sv
package t1cg_pkg;
    localparam int unsigned BYTE_W = 8;

    // number of byte registers needed to hold a mask of the given width
    function automatic int unsigned byte_count(input int unsigned bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction
endpackage

// File: rtl/t1cg_mask_bank.sv
module t1cg_mask_bank
    import t1cg_pkg::*;
#(
    parameter int unsigned CHANNELS  = 24,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 'h6C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [CHANNELS-1:0] staged
);
    localparam int unsigned NREG = byte_count(CHANNELS);

    typedef struct packed {
        logic [CHANNELS-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int r = 0; r < NREG; r++) begin
            if (wr_en && addr == ADDR_W'(BASE_ADDR + r)) begin
                for (int b = 0; b < BYTE_W; b++) begin
                    if (r * BYTE_W + b < CHANNELS) begin
                        bank_d.mask[r * BYTE_W + b] = wdata[b];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign staged = bank_q.mask;
endmodule

// File: rtl/t1cg_frame_timer.sv
module t1cg_frame_timer #(
    parameter int unsigned CHANNELS  = 24,
    parameter int unsigned SLOT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                fsync,
    input  logic [CHANNELS-1:0] staged,
    output logic                gate
);
    localparam int unsigned CH_W  = $clog2(CHANNELS + 1);
    localparam int unsigned BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CHANNELS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    // chan 0 is the framing bit, 1..CHANNELS are timeslots
    typedef struct packed {
        logic [CH_W-1:0]     chan;
        logic [BIT_W-1:0]    bitc;
        logic [CHANNELS-1:0] active;
        logic                gate;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (bit_en) begin
            if (fsync || (tmr_q.chan == LAST_CH && tmr_q.bitc == LAST_BIT)) begin
                tmr_d.chan = '0;
                tmr_d.bitc = '0;
            end else if (tmr_q.chan == '0) begin
                tmr_d.chan = CH_W'(1);
                tmr_d.bitc = '0;
            end else if (tmr_q.bitc == LAST_BIT) begin
                tmr_d.chan = tmr_q.chan + CH_W'(1);
                tmr_d.bitc = '0;
            end else begin
                tmr_d.bitc = tmr_q.bitc + BIT_W'(1);
            end

            if (tmr_d.chan == '0) begin
                tmr_d.active = staged;
                tmr_d.gate   = 1'b0;
            end else begin
                tmr_d.gate = tmr_q.active[tmr_d.chan - CH_W'(1)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.chan   <= LAST_CH;
            tmr_q.bitc   <= LAST_BIT;
            tmr_q.active <= '0;
            tmr_q.gate   <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign gate = tmr_q.gate;
endmodule

// File: rtl/t1_chan_gate.sv
module t1_chan_gate
    import t1cg_pkg::*;
#(
    parameter int unsigned CHANNELS  = 24,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned RX_BASE   = 'h6C,
    parameter int unsigned TX_BASE   = 'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              rx_bit_en,
    input  logic              rx_fsync,
    output logic              rx_gate,
    input  logic              tx_bit_en,
    input  logic              tx_fsync,
    output logic              tx_gate
);
    localparam int unsigned SIDES = 2;

    logic [SIDES-1:0] side_en, side_fs, side_gate;

    assign side_en = {tx_bit_en, rx_bit_en};
    assign side_fs = {tx_fsync, rx_fsync};
    assign rx_gate = side_gate[0];
    assign tx_gate = side_gate[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int unsigned BASE = (s == 0) ? RX_BASE : TX_BASE;
        logic [CHANNELS-1:0] staged;

        t1cg_mask_bank #(
            .CHANNELS (CHANNELS),
            .ADDR_W   (ADDR_W),
            .BASE_ADDR(BASE)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (host_wr),
            .addr  (host_addr),
            .wdata (host_wdata),
            .staged(staged)
        );

        t1cg_frame_timer #(
            .CHANNELS (CHANNELS),
            .SLOT_BITS(SLOT_BITS)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_en(side_en[s]),
            .fsync (side_fs[s]),
            .staged(staged),
            .gate  (side_gate[s])
        );
    end
endmodule

// File: rtl/t1cg_chk.sv
module t1cg_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_bit_en,
    input logic rx_fsync,
    input logic rx_gate,
    input logic tx_bit_en,
    input logic tx_fsync,
    input logic tx_gate
);
    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> $stable(rx_gate));

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit_en |=> $stable(tx_gate));

    // R1
    rx_frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_en && rx_fsync) |=> !rx_gate);

    // R1
    tx_frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_en && tx_fsync) |=> !tx_gate);

    // R10
    rx_reset_chk: assert property (@(posedge clk) !rst_n |=> !rx_gate);

    // R10
    tx_reset_chk: assert property (@(posedge clk) !rst_n |=> !tx_gate);
endmodule

bind t1_chan_gate t1cg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_bit_en(rx_bit_en),
    .rx_fsync (rx_fsync),
    .rx_gate  (rx_gate),
    .tx_bit_en(tx_bit_en),
    .tx_fsync (tx_fsync),
    .tx_gate  (tx_gate)
);

// File: tb/t1_chan_gate_tb.sv
module t1_chan_gate_tb;
    localparam int FRAME = 193;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       rx_bit_en = 1'b0, rx_fsync = 1'b0, tx_bit_en = 1'b0, tx_fsync = 1'b0;
    logic       rx_gate, tx_gate;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model, from requirements
    logic [23:0] stg_rx = '0, stg_tx = '0, act_rx = '0, act_tx = '0;
    int pos = 0;

    // {rx mask, tx mask}
    localparam logic [47:0] VEC [0:5] = '{
        {24'h000000, 24'hFFFFFF},
        {24'hFFFFFF, 24'h000000},
        {24'h000001, 24'h800000},
        {24'h800000, 24'h000001},
        {24'hAAAAAA, 24'h555555},
        {24'h0F00F0, 24'hC3183C}
    };

    always #2.5 clk = ~clk;

    t1_chan_gate u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync),
        .rx_gate(rx_gate), .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync), .tx_gate(tx_gate)
    );

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s pos=%0d got=%0b exp=%0b", req, pos, got, exp);
        end
    endtask

    function automatic logic exp_gate(input logic [23:0] m, input int p);
        return (p == 0) ? 1'b0 : m[(p - 1) / 8];
    endfunction

    function automatic string tag_for(input logic [23:0] m, input int p);
        if (p == 0) return "R1";
        return m[(p - 1) / 8] ? "R2" : "R3";
    endfunction

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        logic rx_before, tx_before;
        @(negedge clk);
        rx_before = rx_gate;
        tx_before = tx_gate;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        if (a >= 8'h6C && a <= 8'h6E) stg_rx[(a - 8'h6C) * 8 +: 8] = d;
        if (a >= 8'h32 && a <= 8'h34) stg_tx[(a - 8'h32) * 8 +: 8] = d;
        // R7: no strobe during the write, outputs hold
        check(rx_gate, rx_before, "R7 rx hold");
        check(tx_gate, tx_before, "R7 tx hold");
    endtask

    task automatic write_masks(input logic [23:0] rm, input logic [23:0] tm);
        for (int i = 0; i < 3; i++) host_write(8'(8'h6C + i), rm[i * 8 +: 8]); // R4
        for (int i = 0; i < 3; i++) host_write(8'(8'h32 + i), tm[i * 8 +: 8]); // R4
    endtask

    task automatic step(input bit fs, input string rtag, input string ttag);
        @(negedge clk);
        rx_bit_en = 1'b1; tx_bit_en = 1'b1; rx_fsync = fs; tx_fsync = fs;
        @(posedge clk);
        @(negedge clk);
        rx_bit_en = 1'b0; tx_bit_en = 1'b0; rx_fsync = 1'b0; tx_fsync = 1'b0;
        pos = fs ? 0 : ((pos == FRAME - 1) ? 0 : pos + 1);
        if (pos == 0) begin
            act_rx = stg_rx;
            act_tx = stg_tx;
        end
        check(rx_gate, exp_gate(act_rx, pos), (rtag == "") ? tag_for(act_rx, pos) : rtag);
        check(tx_gate, exp_gate(act_tx, pos), (ttag == "") ? tag_for(act_tx, pos) : ttag);
    endtask

    task automatic run_frame(input bit fs, input string rtag, input string ttag);
        step(fs, rtag, ttag);
        for (int i = 1; i < FRAME; i++) step(1'b0, rtag, ttag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs low in reset
        check(rx_gate, 1'b0, "R10 rx reset");
        check(tx_gate, 1'b0, "R10 tx reset");
        rst_n = 1'b1;
        // R10: masks zero after reset -> whole frame low
        run_frame(1'b1, "R10", "R10");

        // vector table: each entry written between frames, applied next frame
        for (int v = 0; v < 6; v++) begin
            write_masks(VEC[v][47:24], VEC[v][23:0]);
            run_frame(1'b1, "", "");
        end

        // R8: rewriting only tx bank leaves rx on its mask
        write_masks(24'h00FF00, 24'h0000FF);
        run_frame(1'b1, "", "");
        for (int i = 0; i < 3; i++) host_write(8'(8'h32 + i), 8'h00);
        run_frame(1'b1, "R8", "R8");

        // R9: out-of-range addresses touch neither mask
        host_write(8'h6B, 8'hFF);
        host_write(8'h6F, 8'hFF);
        host_write(8'h31, 8'hFF);
        host_write(8'h35, 8'hFF);
        run_frame(1'b1, "R9", "R9");

        // R5: write mid-frame; current frame keeps old mask, next frame uses new
        step(1'b1, "R5", "R5");
        for (int i = 1; i < 40; i++) step(1'b0, "R5", "R5");
        write_masks(24'hFFFFFF, 24'hF0F0F0);
        for (int i = 40; i < FRAME; i++) step(1'b0, "R5", "R5");
        run_frame(1'b1, "R5", "R5");

        // R6: mid-frame frame sync realigns
        write_masks(24'h000003, 24'h000005);
        step(1'b1, "R6", "R6");
        for (int i = 1; i < 50; i++) step(1'b0, "R6", "R6");
        run_frame(1'b1, "R6", "R6");

        // R6: free-running wrap after 193 bits without frame sync
        run_frame(1'b0, "R6", "R6");
        run_frame(1'b0, "R6", "R6");

        // R7: long idle, outputs hold
        step(1'b0, "R7", "R7");
        begin
            logic rh, th;
            rh = rx_gate;
            th = tx_gate;
            repeat (10) @(negedge clk);
            check(rx_gate, rh, "R7 rx idle");
            check(tx_gate, th, "R7 tx idle");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule